// File: doc/BRIEF.md
# Three-Wire Word-Length-Sensing Tuning Receiver

This block receives tuning words over a three-line serial link made of an enable line, a clock line and a data line, all asynchronous to the system clock. While the enable line is high, one data bit is captured on each falling clock edge and the rising clock edges are counted. The first four bits set the band-select outputs as soon as the fifth rising edge arrives. The remaining bits form the divider word and, in the longest frame, a control field.

The length of the frame carries information of its own. The receiver counts the bits and, when enable falls, uses that count to decide what to load:
- A short frame carries a 14-bit divider word and selects one reference ratio.
- A medium frame carries the full 15-bit word and selects the other ratio.
- A long frame also carries charge-pump, test, ratio and tuning-disable settings. These settings can change in no other way.

All outputs are plain registers. Each register group has a one-cycle load pulse. There is no handshake and no back-pressure: a pulse only signals that new values are in place, and a consumer must take them in that cycle or read the register level later.

Top module: `tw3_rx`

## Requirements
- R1: After reset, band_o=0, freq_o=0, cp_o=1, test_o=3'b001, rsa_o=RSA_INIT (default 1), rsb_o=RSB_INIT (default 1), os_o=1, and all load pulses are low.
- R2: Clock or data activity while the enable line is low changes no output and produces no load pulse.
- R3: Bits 1..4 of a frame load into band_o at the 5th rising clock edge. Bit 1 goes to band_o[3] and bit 4 to band_o[0]. band_ld_o pulses once. A frame with fewer than 5 bits leaves band_o unchanged.
- R4: When enable falls after exactly 18 bits, freq_o becomes {0, bits 5..18}, with bit 5 as the MSB of the 14-bit part, and rsa_o becomes 1.
- R5: When enable falls after exactly 19 bits, freq_o becomes bits 5..19, with bit 5 as freq_o[14], and rsa_o becomes 0.
- R6: In any frame that reaches a 20th rising clock edge, freq_o loads bits 5..19 at that edge, with bit 5 as freq_o[14].
- R7: When enable falls after exactly 27 bits, bits 20..27 are taken as marker, cp, test[2], test[1], test[0], rsa, rsb, os, in that order. The marker bit is ignored. The other fields load, and ctrl_ld_o pulses once.
- R8: cp_o, test_o, rsb_o and os_o change only at the end of a 27-bit frame. They keep their values across later 18-bit and 19-bit frames.
- R9: At enable fall, a frame of any length other than 18, 19 or 27 loads nothing. In particular, frames under 18 bits leave freq_o untouched.
- R10: The edge and bit counters saturate at 31 within a frame. A frame longer than 31 bits gives exactly one band load and one divider load, and nothing at enable fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ce_i | input | 1 | Frame enable line (asynchronous) |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line (asynchronous) |
| band_o | output | 4 | Band-select bits |
| band_ld_o | output | 1 | One-cycle pulse when band_o loads |
| freq_o | output | 15 | Divider word |
| freq_ld_o | output | 1 | One-cycle pulse when freq_o loads |
| cp_o | output | 1 | Charge-pump current select |
| test_o | output | 3 | Test-mode bits |
| rsa_o | output | 1 | Reference ratio bit A |
| rsb_o | output | 1 | Reference ratio bit B |
| os_o | output | 1 | Tuning output disable |
| ctrl_ld_o | output | 1 | One-cycle pulse when the control field loads |

## Verification
The hardest case to reach from the ports is a frame that passes 31 bits: only there can counter wrap-around show up, as a second band or divider load. The stimulus sends a directed 40-bit frame and counts the load pulses. A second hard case is a frame of 20 to 26 bits, where the divider loads in mid-frame but nothing loads at enable fall. Random frame lengths are drawn between 1 and 35, mixed with the three valid lengths, so these cases recur with fresh data.

// File: rtl/tw3_pkg.sv
package tw3_pkg;
  localparam int BAND_BITS = 4;
  localparam int FREQ_BITS = 15;
  localparam int CTRL_BITS = 8;

  typedef struct packed {
    logic       cp;
    logic [2:0] test;
    logic       rsb;
    logic       os;
  } tw3_ctl_t;
endpackage

// File: rtl/tw3_sync.sv
module tw3_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], din[i]};
    end
    assign lvl[i]  = pipe[STAGES-1];
    assign rise[i] = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall[i] = ~pipe[STAGES-1] & pipe[STAGES];
  end
endmodule

// File: rtl/tw3_frame.sv
module tw3_frame #(
  parameter int CNT_W     = 5,
  parameter int SH_W      = 15,
  parameter int BAND_EDGE = 5,
  parameter int FREQ_EDGE = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_lvl,
  input  logic             ce_rise,
  input  logic             ce_fall,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  output logic             band_evt,
  output logic             freq_evt,
  output logic             end_evt,
  output logic [CNT_W-1:0] len_o,
  output logic [SH_W-1:0]  shreg_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] BAND_PRE = CNT_W'(BAND_EDGE - 1);
  localparam logic [CNT_W-1:0] FREQ_PRE = CNT_W'(FREQ_EDGE - 1);

  logic [CNT_W-1:0] rise_cnt;
  logic [CNT_W-1:0] bit_cnt;
  logic [SH_W-1:0]  shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      bit_cnt  <= '0;
      shreg    <= '0;
    end else if (ce_rise) begin
      rise_cnt <= '0;
      bit_cnt  <= '0;
    end else if (ce_lvl) begin
      if (scl_rise && rise_cnt != CNT_MAX) rise_cnt <= rise_cnt + 1'b1;
      if (scl_fall) begin
        shreg <= {shreg[SH_W-2:0], sda_lvl};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign band_evt = ce_lvl && scl_rise && (rise_cnt == BAND_PRE);
  assign freq_evt = ce_lvl && scl_rise && (rise_cnt == FREQ_PRE);
  assign end_evt  = ce_fall;
  assign len_o    = bit_cnt;
  assign shreg_o  = shreg;

  AST_CNT_NOWRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_lvl && !ce_rise) |=> (rise_cnt >= $past(rise_cnt) && bit_cnt >= $past(bit_cnt))); // R10
  AST_IDLE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_lvl |=> $stable(shreg)); // R2
endmodule

// File: rtl/tw3_regs.sv
module tw3_regs
  import tw3_pkg::*;
#(
  parameter int   BAND_W   = BAND_BITS,
  parameter int   FREQ_W   = FREQ_BITS,
  parameter int   CTRL_W   = CTRL_BITS,
  parameter int   CNT_W    = 5,
  parameter logic RSB_INIT = 1'b1,
  parameter logic RSA_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              band_evt,
  input  logic              freq_evt,
  input  logic              end_evt,
  input  logic [CNT_W-1:0]  len,
  input  logic [FREQ_W-1:0] shreg,
  output logic [BAND_W-1:0] band_q,
  output logic              band_ld_q,
  output logic [FREQ_W-1:0] freq_q,
  output logic              freq_ld_q,
  output tw3_ctl_t          ctl_q,
  output logic              rsa_q,
  output logic              ctrl_ld_q
);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(BAND_W + FREQ_W - 1);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(BAND_W + FREQ_W);
  localparam logic [CNT_W-1:0] LEN_FULL  = CNT_W'(BAND_W + FREQ_W + CTRL_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q    <= '0;
      freq_q    <= '0;
      ctl_q     <= '{cp: 1'b1, test: 3'b001, rsb: RSB_INIT, os: 1'b1};
      rsa_q     <= RSA_INIT;
      band_ld_q <= 1'b0;
      freq_ld_q <= 1'b0;
      ctrl_ld_q <= 1'b0;
    end else begin
      band_ld_q <= 1'b0;
      freq_ld_q <= 1'b0;
      ctrl_ld_q <= 1'b0;
      if (band_evt) begin
        band_q    <= shreg[BAND_W-1:0];
        band_ld_q <= 1'b1;
      end
      if (freq_evt) begin
        freq_q    <= shreg;
        freq_ld_q <= 1'b1;
      end
      if (end_evt) begin
        if (len == LEN_SHORT) begin
          freq_q    <= {1'b0, shreg[FREQ_W-2:0]};
          rsa_q     <= 1'b1;
          freq_ld_q <= 1'b1;
        end else if (len == LEN_LONG) begin
          freq_q    <= shreg;
          rsa_q     <= 1'b0;
          freq_ld_q <= 1'b1;
        end else if (len == LEN_FULL) begin
          ctl_q.cp   <= shreg[6];
          ctl_q.test <= shreg[5:3];
          rsa_q      <= shreg[2];
          ctl_q.rsb  <= shreg[1];
          ctl_q.os   <= shreg[0];
          ctrl_ld_q  <= 1'b1;
        end
      end
    end
  end

  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !band_ld_q |-> $stable(band_q)); // R3
  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_ld_q |-> $stable(freq_q)); // R9
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_ld_q |-> $stable(ctl_q)); // R8
  AST_RSA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!freq_ld_q && !ctrl_ld_q) |-> $stable(rsa_q)); // R7
  AST_SHORT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && len == LEN_SHORT) |=> (!freq_q[FREQ_W-1] && rsa_q)); // R4
  AST_LONG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && len == LEN_LONG) |=> !rsa_q); // R5
endmodule

// File: rtl/tw3_rx.sv
module tw3_rx
  import tw3_pkg::*;
#(
  parameter int   CNT_W       = 5,
  parameter int   SYNC_STAGES = 2,
  parameter logic RSB_INIT    = 1'b1,
  parameter logic RSA_INIT    = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_i,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic [3:0]  band_o,
  output logic        band_ld_o,
  output logic [14:0] freq_o,
  output logic        freq_ld_o,
  output logic        cp_o,
  output logic [2:0]  test_o,
  output logic        rsa_o,
  output logic        rsb_o,
  output logic        os_o,
  output logic        ctrl_ld_o
);
  localparam int BAND_W    = BAND_BITS;
  localparam int FREQ_W    = FREQ_BITS;
  localparam int CTRL_W    = CTRL_BITS;
  localparam int BAND_EDGE = BAND_W + 1;
  localparam int FREQ_EDGE = BAND_W + FREQ_W + 1;

  logic [2:0] lvl, rise, fall;
  logic band_evt, freq_evt, end_evt;
  logic [CNT_W-1:0]  len;
  logic [FREQ_W-1:0] shreg;
  tw3_ctl_t ctl;

  tw3_sync #(.LINES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sda_i, scl_i, ce_i}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  tw3_frame #(.CNT_W(CNT_W), .SH_W(FREQ_W), .BAND_EDGE(BAND_EDGE),
              .FREQ_EDGE(FREQ_EDGE)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .ce_lvl(lvl[0]), .ce_rise(rise[0]), .ce_fall(fall[0]),
    .scl_rise(rise[1]), .scl_fall(fall[1]), .sda_lvl(lvl[2]),
    .band_evt(band_evt), .freq_evt(freq_evt), .end_evt(end_evt),
    .len_o(len), .shreg_o(shreg)
  );

  tw3_regs #(.BAND_W(BAND_W), .FREQ_W(FREQ_W), .CTRL_W(CTRL_W), .CNT_W(CNT_W),
             .RSB_INIT(RSB_INIT), .RSA_INIT(RSA_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .band_evt(band_evt), .freq_evt(freq_evt), .end_evt(end_evt),
    .len(len), .shreg(shreg),
    .band_q(band_o), .band_ld_q(band_ld_o),
    .freq_q(freq_o), .freq_ld_q(freq_ld_o),
    .ctl_q(ctl), .rsa_q(rsa_o), .ctrl_ld_q(ctrl_ld_o)
  );

  assign cp_o   = ctl.cp;
  assign test_o = ctl.test;
  assign rsb_o  = ctl.rsb;
  assign os_o   = ctl.os;

  AST_PULSE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(band_ld_o && (freq_ld_o || ctrl_ld_o))); // R3
endmodule

// File: tb/sim_tw3_rx.sv
module sim_tw3_rx;
  logic clk = 0, rst_n = 0, ce = 0, scl = 0, sda = 0;
  logic [3:0] band_o; logic band_ld_o;
  logic [14:0] freq_o; logic freq_ld_o;
  logic cp_o, rsa_o, rsb_o, os_o, ctrl_ld_o;
  logic [2:0] test_o;

  always #2 clk = ~clk;

  tw3_rx u0 (.clk(clk), .rst_n(rst_n), .ce_i(ce), .scl_i(scl), .sda_i(sda),
    .band_o(band_o), .band_ld_o(band_ld_o), .freq_o(freq_o), .freq_ld_o(freq_ld_o),
    .cp_o(cp_o), .test_o(test_o), .rsa_o(rsa_o), .rsb_o(rsb_o), .os_o(os_o),
    .ctrl_ld_o(ctrl_ld_o));

  int errors = 0, checks = 0;
  int n_band = 0, n_freq = 0, n_ctrl = 0;
  bit done = 0;
  logic [3:0] e_band; logic [14:0] e_freq;
  logic e_cp, e_rsa, e_rsb, e_os; logic [2:0] e_test;

  always @(posedge clk) begin
    if (band_ld_o) n_band++;
    if (freq_ld_o) n_freq++;
    if (ctrl_ld_o) n_ctrl++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_freq_pulses(int len);
    return (len >= 20 ? 1 : 0) + ((len == 18 || len == 19) ? 1 : 0);
  endfunction

  task automatic model(logic [63:0] w, int len);
    if (len >= 5) e_band = w[len-1 -: 4];
    if (len >= 20) e_freq = w[len-5 -: 15];
    if (len == 18) begin e_freq = {1'b0, w[13:0]}; e_rsa = 1'b1; end
    if (len == 19) begin e_freq = w[14:0]; e_rsa = 1'b0; end
    if (len == 27) begin
      e_cp = w[6]; e_test = w[5:3]; e_rsa = w[2]; e_rsb = w[1]; e_os = w[0];
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " R3 band"}, 32'(band_o), 32'(e_band));
    check({tag, " R9 freq"}, 32'(freq_o), 32'(e_freq));
    check({tag, " R4 rsa"}, 32'(rsa_o), 32'(e_rsa));
    check({tag, " R8 ctrl"}, {26'd0, cp_o, test_o, rsb_o, os_o},
          {26'd0, e_cp, e_test, e_rsb, e_os});
  endtask

  task automatic send(logic [63:0] w, int len, string tag);
    int b0 = n_band, f0 = n_freq, c0 = n_ctrl;
    ce = 1; wait_n(10);
    for (int k = 1; k <= len; k++) begin
      sda = w[len-k]; wait_n(4);
      scl = 1; wait_n(4);
      if (k == 5) check({tag, " R3 band mid-frame"}, 32'(band_o), 32'(w[len-1 -: 4]));
      if (k == 20) check({tag, " R6 freq at 20th edge"}, 32'(freq_o), 32'(w[len-5 -: 15]));
      scl = 0; wait_n(4);
    end
    ce = 0; wait_n(10);
    model(w, len);
    check_all(tag);
    check({tag, " R10 band pulses"}, 32'(n_band - b0), (len >= 5) ? 1 : 0);
    check({tag, " R10 freq pulses"}, 32'(n_freq - f0), 32'(exp_freq_pulses(len)));
    check({tag, " R7 ctrl pulses"}, 32'(n_ctrl - c0), (len == 27) ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    e_band = 0; e_freq = 0; e_cp = 1; e_test = 3'b001; e_rsa = 1; e_rsb = 1; e_os = 1;
    wait_n(5); rst_n = 1; wait_n(3);
    // R1 reset state
    check_all("R1 reset");
    check("R1 pulses", {29'd0, band_ld_o, freq_ld_o, ctrl_ld_o}, 0);

    // R2 activity with enable low
    for (int k = 0; k < 30; k++) begin
      sda = k[0]; wait_n(3); scl = 1; wait_n(3); scl = 0; wait_n(3);
    end
    wait_n(6);
    check_all("R2 idle");
    check("R2 no pulses", 32'(n_band + n_freq + n_ctrl), 0);

    send(64'h2_AB3C, 18, "R4 short");
    send(64'h5_6789, 19, "R5 medium");
    send({37'd0, 4'b0001, 15'h2F0F, 8'b1_0_000_0_0_0}, 27, "R7 full");
    send(64'h3_1234, 18, "R8 keep ctrl");
    send({37'd0, 4'b1010, 15'h7FFF, 8'b1_1_110_1_0_1}, 27, "R7 full2");
    send(64'h35A, 10, "R9 short frame");
    send(64'h5, 3, "R3 tiny frame");
    send(64'h7A_BCDE, 23, "R9 invalid 23");
    send(64'hF1_2345_6789, 40, "R10 long 40");

    for (int i = 0; i < 40; i++) begin
      int len;
      logic [63:0] w;
      case ($urandom % 4)
        0: len = 18;
        1: len = 19;
        2: len = 27;
        default: len = 1 + ($urandom % 35);
      endcase
      w = {$urandom, $urandom};
      send(w, len, "random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule